// File: doc/BRIEF.md
# Seconds Real-Time Clock with Match Alarm

This block keeps wall-clock time as a 32-bit count of seconds. A prescaler divides the system clock by a parameter value and produces a one-cycle tick once per second. Each tick advances the count by one. A programmable match value raises a level interrupt when the count reaches it. The interrupt can be masked, and it stays raised until software clears it.

Software reaches the block through a small register bus. Each request is one cycle with `bus_valid` high, plus a write flag, a 12-bit byte address and write data. The block never applies back-pressure. Every request is accepted in the cycle it is presented, and `bus_ready` answers it exactly one cycle later. For a read, `bus_rdata` carries the data in that same cycle. A master may issue a new request on every cycle. Registers are decoded on word addresses within a 4 KB window.

The register word offsets are:
- 0x00: seconds count (read only)
- 0x04: match value
- 0x08: load value
- 0x0C: control
- 0x10: interrupt mask
- 0x14: raw status
- 0x18: masked status
- 0x1C: status clear (write only)
- 0xFE0 to 0xFFC: identification bytes

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset the count, match value, load value, mask and raw status are all zero, and `irq` and `bus_ready` are low.
- R2: The count increases by one once every PRESCALE clock cycles. The first increase comes PRESCALE cycles after reset is released. The count wraps from 0xFFFFFFFF to 0.
- R3: Writing 0x08 sets the count to the written value on the next edge, and reads of 0x08 return the last value written. A load wins over a tick in the same cycle. The match is evaluated again against the loaded value.
- R4: Writing 0x04 stores the match value, which reads back at 0x04. If the new match equals the count after that edge, raw status is set on that same edge.
- R5: When the count, through a tick, becomes equal to the match value, raw status bit 0 is set. A match below the count therefore fires only after the count wraps.
- R6: A write to 0x10 keeps only data bit 0 as the mask. `irq` equals raw status AND mask. Reading 0x18 returns that AND in bit 0.
- R7: A write to 0x1C with data bit 0 set clears raw status, and with bit 0 clear it leaves raw status unchanged. If an alarm event occurs in the same cycle as the clear, the status stays set.
- R8: Reading 0x0C returns 1, and writes to 0x0C are ignored. Reads of 0x1C and of unmapped offsets return 0. Writes to 0x00, 0x14 and 0x18 change nothing.
- R9: Reading word offset 0xFE0 + 4*i, for i = 0..7, returns in bits 7:0 the byte i of the sequence 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1, with the upper bits zero.
- R10: Every cycle with `bus_valid` high is followed, one cycle later, by one cycle of `bus_ready`. A read returns the register state from before the edge that accepted it. A write answers with `bus_rdata` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Response strobe, one cycle after each request |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| irq | output | 1 | Level interrupt: raw status AND mask |

## Verification
The results fall due at different times:
- A read's data and `bus_ready` appear one cycle after the request.
- Count, match and status changes caused by a write show at the next edge, so a read issued the cycle after the write already sees them.
- `irq` follows one edge after the event or the mask write.

The bench's reference model advances on each rising edge from the same inputs. The outputs are compared at each falling edge, so every result is checked in the cycle it becomes due. Directed cases line up with the model's prescaler phase, to force a load or a clear into the same cycle as a tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned WIDX_W = ADDR_W - 2;

  localparam logic [WIDX_W-1:0] W_COUNT = 10'd0;
  localparam logic [WIDX_W-1:0] W_MATCH = 10'd1;
  localparam logic [WIDX_W-1:0] W_LOAD  = 10'd2;
  localparam logic [WIDX_W-1:0] W_CTRL  = 10'd3;
  localparam logic [WIDX_W-1:0] W_MASK  = 10'd4;
  localparam logic [WIDX_W-1:0] W_RAW   = 10'd5;
  localparam logic [WIDX_W-1:0] W_MSK   = 10'd6;
  localparam logic [WIDX_W-1:0] W_CLR   = 10'd7;
  // identification window: word index upper bits all ones
  localparam logic [WIDX_W-4:0] ID_PAGE = '1;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h31;
      3'd1: id_byte = 8'h10;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;

  assign tick = (phase_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    phase_q <= '0;
    else if (tick) phase_q <= '0;
    else           phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt
);
  always_comb begin
    if (load_en)   cnt_nxt = load_val;   // load beats tick
    else if (tick) cnt_nxt = cnt_q + 1'b1; // wraps modulo 2^W
    else           cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_nxt,
  input  logic         cnt_step,
  input  logic         match_we,
  input  logic [W-1:0] match_wdata,
  input  logic         mask_we,
  input  logic         mask_bit,
  input  logic         clr_we,
  input  logic         clr_bit,
  output logic [W-1:0] match_q,
  output logic         mask_q,
  output logic         raw_q,
  output logic         alarm_evt
);
  logic [W-1:0] match_nxt;

  assign match_nxt = match_we ? match_wdata : match_q;
  // evaluate only when count or match changes, so equality fires once
  assign alarm_evt = (cnt_step || match_we) && (cnt_nxt == match_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      mask_q  <= 1'b0;
      raw_q   <= 1'b0;
    end else begin
      match_q <= match_nxt;
      if (mask_we) mask_q <= mask_bit;
      if (alarm_evt)                raw_q <= 1'b1;  // event wins over clear
      else if (clr_we && clr_bit)   raw_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
  import rtc_pkg::*;
#(
  parameter int unsigned PRESCALE = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              bus_ready,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              tick;
  logic              wr;
  logic [WIDX_W-1:0] widx;
  logic              we_load, we_match, we_mask, we_clr;
  logic [DATA_W-1:0] cnt_q, cnt_nxt, match_q, load_q, rd_mux;
  logic              mask_q, raw_q, alarm_evt;

  assign wr       = bus_valid && bus_write;
  assign widx     = bus_addr[ADDR_W-1:2];
  assign we_load  = wr && (widx == W_LOAD);
  assign we_match = wr && (widx == W_MATCH);
  assign we_mask  = wr && (widx == W_MASK);
  assign we_clr   = wr && (widx == W_CLR);

  rtc_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  rtc_seconds #(.W(DATA_W)) u_secs (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load_en(we_load),
    .load_val(bus_wdata), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  rtc_alarm #(.W(DATA_W)) u_alarm (
    .clk(clk), .rst_n(rst_n), .cnt_nxt(cnt_nxt),
    .cnt_step(tick || we_load),
    .match_we(we_match), .match_wdata(bus_wdata),
    .mask_we(we_mask), .mask_bit(bus_wdata[0]),
    .clr_we(we_clr), .clr_bit(bus_wdata[0]),
    .match_q(match_q), .mask_q(mask_q), .raw_q(raw_q), .alarm_evt(alarm_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       load_q <= '0;
    else if (we_load) load_q <= bus_wdata;
  end

  always_comb begin
    rd_mux = '0;
    if (widx[WIDX_W-1:3] == ID_PAGE) begin
      rd_mux[7:0] = id_byte(widx[2:0]);
    end else begin
      case (widx)
        W_COUNT: rd_mux = cnt_q;
        W_MATCH: rd_mux = match_q;
        W_LOAD:  rd_mux = load_q;
        W_CTRL:  rd_mux[0] = 1'b1;
        W_MASK:  rd_mux[0] = mask_q;
        W_RAW:   rd_mux[0] = raw_q;
        W_MSK:   rd_mux[0] = raw_q & mask_q;
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_valid;
      bus_rdata <= (bus_valid && !bus_write) ? rd_mux : '0;
    end
  end

  assign irq = raw_q & mask_q;
endmodule

// File: rtl/rtc_sec_alarm_chk.sv
module rtc_sec_alarm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_ready,
  input logic [31:0] bus_rdata,
  input logic        tick,
  input logic [31:0] cnt_q,
  input logic        mask_q,
  input logic        raw_q,
  input logic        alarm_evt
);
  logic is_load, is_match, is_mask, is_clr, rd_ctrl;
  assign is_load  = bus_valid && bus_write && (bus_addr[11:2] == 10'd2);
  assign is_match = bus_valid && bus_write && (bus_addr[11:2] == 10'd1);
  assign is_mask  = bus_valid && bus_write && (bus_addr[11:2] == 10'd4);
  assign is_clr   = bus_valid && bus_write && (bus_addr[11:2] == 10'd7);
  assign rd_ctrl  = bus_valid && !bus_write && (bus_addr[11:2] == 10'd3);

  a_r10_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> bus_ready);
  a_r10_no_spurious_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !bus_ready);
  a_r3_load_sets_count: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |=> cnt_q == $past(bus_wdata));
  a_r2_tick_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !is_load) |=> cnt_q == $past(cnt_q) + 32'd1);
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !is_load) |=> $stable(cnt_q));
  a_r4_match_fires_now: assert property (@(posedge clk) disable iff (!rst_n)
    (is_match && !tick && bus_wdata == cnt_q) |=> raw_q);
  a_r7_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> raw_q);
  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (is_clr && bus_wdata[0] && !alarm_evt) |=> !raw_q);
  a_r6_mask_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    is_mask |=> mask_q == $past(bus_wdata[0]));
  a_r8_ctrl_reads_one: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |=> bus_rdata == 32'd1);
endmodule

bind rtc_sec_alarm rtc_sec_alarm_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
  .bus_rdata(bus_rdata), .tick(tick), .cnt_q(cnt_q), .mask_q(mask_q),
  .raw_q(raw_q), .alarm_evt(alarm_evt)
);

// File: tb/test_rtc_sec_alarm.sv
`timescale 1ns/1ps
module test_rtc_sec_alarm;
  localparam int DIV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rtc_sec_alarm #(.PRESCALE(DIV)) i_rtc_sec_alarm (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_cnt = 0, m_match = 0, m_lv = 0, m_rdata = 0;
  bit m_mask = 0, m_raw = 0, m_ready = 0, m_isread = 0;
  int m_pc = 0;
  string m_tag = "R10";
  byte unsigned ids[8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  always @(posedge clk) begin : model
    int a;
    bit tk, wr, ev;
    logic [31:0] nc, nm;
    if (!rst_n) begin
      m_cnt = 0; m_match = 0; m_lv = 0; m_mask = 0; m_raw = 0;
      m_pc = 0; m_ready = 0; m_isread = 0;
    end else begin
      a = int'(bus_addr) / 4;
      tk = (m_pc == DIV - 1);
      wr = bus_valid && bus_write;
      m_ready = bus_valid;
      m_isread = bus_valid && !bus_write;
      if (m_isread) begin
        if (a >= 1016) begin m_rdata = {24'd0, ids[a - 1016]}; m_tag = "R9"; end
        else case (a)
          0: begin m_rdata = m_cnt; m_tag = "R2"; end
          1: begin m_rdata = m_match; m_tag = "R4"; end
          2: begin m_rdata = m_lv; m_tag = "R3"; end
          3: begin m_rdata = 1; m_tag = "R8"; end
          4: begin m_rdata = {31'd0, m_mask}; m_tag = "R6"; end
          5: begin m_rdata = {31'd0, m_raw}; m_tag = "R5"; end
          6: begin m_rdata = {31'd0, m_raw & m_mask}; m_tag = "R6"; end
          default: begin m_rdata = 0; m_tag = "R8"; end
        endcase
      end
      nc = (wr && a == 2) ? bus_wdata : (tk ? m_cnt + 1 : m_cnt);
      nm = (wr && a == 1) ? bus_wdata : m_match;
      ev = (tk || (wr && (a == 1 || a == 2))) && (nc == nm);
      if (ev) m_raw = 1;
      else if (wr && a == 7 && bus_wdata[0]) m_raw = 0;
      if (wr && a == 4) m_mask = bus_wdata[0];
      if (wr && a == 2) m_lv = bus_wdata;
      m_cnt = nc; m_match = nm;
      m_pc = tk ? 0 : m_pc + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(irq == (m_raw & m_mask), "R6 irq", {31'd0, irq}, {31'd0, m_raw & m_mask});
      chk(bus_ready == m_ready, "R10 ready", {31'd0, bus_ready}, {31'd0, m_ready});
      if (m_ready && m_isread)
        chk(bus_rdata == m_rdata, m_tag, bus_rdata, m_rdata);
    end
  end

  // ---------------- stimulus tasks (called at falling edges) ----------------
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
  endtask

  task automatic rd_exp(input logic [11:0] a, input logic [31:0] e, input string tag);
    logic [31:0] d;
    rd(a, d);
    chk(d === e, tag, d, e);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(irq == 0, "R1 irq", {31'd0, irq}, 0);
    chk(bus_ready == 0, "R1 ready", {31'd0, bus_ready}, 0);
    rd_exp(12'h000, 0, "R1 count");
    rd_exp(12'h004, 0, "R1 match");
    rd_exp(12'h010, 0, "R1 mask");
    rd_exp(12'h014, 0, "R1 raw");
    // R2 first tick after PRESCALE cycles: count has stepped once by now
    repeat (DIV - 3) @(negedge clk);
    rd_exp(12'h000, 1, "R2 first tick");
    // R8 control / unmapped / clear read
    wr(12'h00C, 0);
    rd_exp(12'h00C, 1, "R8 ctrl");
    rd_exp(12'h01C, 0, "R8 clr read");
    rd_exp(12'h020, 0, "R8 unmapped");
    rd_exp(12'h800, 0, "R8 unmapped high");
    // R9 identification bytes
    for (int i = 0; i < 8; i++) rd_exp(12'hFE0 + 12'(4 * i), {24'd0, ids[i]}, "R9 id");
    // R6 only bit 0 of mask kept
    wr(12'h010, 32'hFFFF_FFFE);
    rd_exp(12'h010, 0, "R6 mask bit0 zero");
    wr(12'h010, 32'h0000_0003);
    rd_exp(12'h010, 1, "R6 mask bit0 one");
    // R3 load beats tick
    while (m_pc != DIV - 1) @(negedge clk);
    wr(12'h008, 32'd1000);
    rd_exp(12'h000, 32'd1000, "R3 load beats tick");
    rd_exp(12'h008, 32'd1000, "R3 load readback");
    // R8 writes to read-only regs ignored
    while (m_pc >= DIV - 3) @(negedge clk);
    wr(12'h000, 32'hDEAD);
    wr(12'h014, 1);
    wr(12'h018, 1);
    rd_exp(12'h000, 32'd1000, "R8 count write ignored");
    rd_exp(12'h014, 0, "R8 raw write ignored");
    // R4 match equal to current count fires at once
    while (m_pc >= DIV - 3) @(negedge clk);
    wr(12'h004, m_cnt);
    chk(irq == 1, "R4 immediate", {31'd0, irq}, 1);
    rd_exp(12'h018, 1, "R6 masked status");
    // R7 clear with bit0 zero keeps, bit0 one clears
    wr(12'h01C, 32'hFFFF_FFFE);
    rd_exp(12'h014, 1, "R7 clear bit0 zero");
    wr(12'h01C, 1);
    rd_exp(12'h014, 0, "R7 clear");
    // R3 load re-evaluates match
    wr(12'h004, 32'd5000);
    wr(12'h008, 32'd5000);
    rd_exp(12'h014, 1, "R3 load fires");
    wr(12'h01C, 1);
    // R7 alarm wins over clear in same cycle
    while (m_pc >= DIV - 3) @(negedge clk);
    wr(12'h004, m_cnt + 1);
    wr(12'h01C, 1);
    while (m_pc != DIV - 1) @(negedge clk);
    wr(12'h01C, 1);
    rd_exp(12'h014, 1, "R7 alarm wins");
    wr(12'h01C, 1);
    // R6 masked off: raw set but irq low
    wr(12'h010, 0);
    wr(12'h004, 32'd7);
    wr(12'h008, 32'd7);
    chk(irq == 0, "R6 masked irq", {31'd0, irq}, 0);
    rd_exp(12'h018, 0, "R6 masked status off");
    rd_exp(12'h014, 1, "R6 raw under mask");
    wr(12'h01C, 1);
    wr(12'h010, 1);
    // R5 match below count fires only after wrap
    while (m_pc >= DIV - 3) @(negedge clk);
    wr(12'h004, 32'd1);
    wr(12'h008, 32'hFFFF_FFFE);
    repeat (DIV - 2) @(negedge clk);
    chk(irq == 0, "R5 no early fire", {31'd0, irq}, 0);
    repeat (4 * DIV) @(negedge clk);
    chk(irq == 1, "R5 fires after wrap", {31'd0, irq}, 1);
    rd_exp(12'h014, 1, "R5 raw after wrap");
    chk(m_cnt < 32'd10, "R2 wrapped", m_cnt, 32'd4);
    repeat (20) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule